// File: doc/BRIEF.md
# PHY Interrupt, Diagnostic and Transceiver Control Registers

This block holds three 16-bit management registers for an Ethernet PHY and is read and written through a simple single-cycle register port, the kind a serial management engine drives after decoding a frame. Eight PHY events latch into sticky status bits. Each status bit has an enable bit in the same word. A single interrupt request goes to the MAC whenever an enabled status bit is set. Reading the status word clears the bits that the read returned as 1.

A second register reports the outcome of auto-negotiation. It carries a sticky failure flag that clears on read, plus four live status levels: duplex, rate, receive signal detect and receive PLL lock. A third register holds a two-bit transmit amplitude code. The serial framing, the auto-negotiation engine and the analog driver are outside the block. Their results arrive as synchronous inputs.

Read data is combinational from `mgmt_addr` and is valid in the cycle `mgmt_rd` is high. Any clear-on-read takes effect at the clock edge that ends that cycle. Event inputs are one-cycle pulses. `link_ok` is a level.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, address 0x11 reads 0x0000, address 0x12 reads 0x0000, address 0x13 reads 0x4000, and `phy_irq` is low.
- R2: A pulse on an event input sets its status bit at address 0x11, and the bit stays set until that word is read. The bit positions are: bit 0 auto-negotiation complete, bit 1 remote fault, bit 2 link went down, bit 3 partner acknowledge, bit 4 parallel detection fault, bit 5 page received, bit 6 receive error, bit 7 jabber.
- R3: A read of 0x11 returns the enables in bits 15:8 and the status in bits 7:0. Afterwards it clears exactly the status bits it returned as 1 and leaves the enables unchanged.
- R4: An event arriving in the same cycle as a clearing read of 0x11 leaves its status bit set after the read.
- R5: `phy_irq` is high exactly when some status bit n is set and enable bit n+8 is also set.
- R6: Status bit 2 is set only on a high-to-low transition of `link_ok`. A low-to-high transition sets nothing.
- R7: A write to 0x11 updates bits 15:8 only. Status bits 7:0 are not affected by writes.
- R8: At 0x12, bits 11, 10, 9 and 8 show the live levels of `st_full_duplex`, `st_rate_100`, `st_rx_signal` and `st_rx_lock`. Bits 15:13 and 7:0 read as zero. Writes to 0x12 are ignored.
- R9: A pulse on `aneg_fail` sets bit 12 of 0x12. The bit stays set until 0x12 is read and survives a read that coincides with a new pulse.
- R10: Bits 15:14 of 0x13 hold the writable amplitude code, where codes 0 to 3 select 0.0, 0.4, 0.8 and 1.2 dB of compensation. Bits 13:0 always read as zero.
- R11: Reads of any other address return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_addr | input | 5 | Register address |
| mgmt_rd | input | 1 | Read strobe; arms clear-on-read at the next edge |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data for `mgmt_addr` |
| ev_jabber | input | 1 | Jabber event pulse |
| ev_rx_err | input | 1 | Receive error event pulse |
| ev_page_rx | input | 1 | Page received event pulse |
| ev_pd_fault | input | 1 | Parallel detection fault event pulse |
| ev_lp_ack | input | 1 | Link partner acknowledge event pulse |
| ev_rfault | input | 1 | Remote fault event pulse |
| ev_aneg_done | input | 1 | Auto-negotiation complete event pulse |
| link_ok | input | 1 | Link status level, 1 = OK |
| aneg_fail | input | 1 | Auto-negotiation failure pulse |
| st_full_duplex | input | 1 | Resolved full duplex level |
| st_rate_100 | input | 1 | Resolved 100 Mb/s level |
| st_rx_signal | input | 1 | Receive signal detected level |
| st_rx_lock | input | 1 | Receive PLL locked level |
| phy_irq | output | 1 | Combined interrupt request |

## Verification
A lost or stuck status bit shows at the ports in two ways. It shows on `phy_irq` one cycle after the event if its enable is set, and it shows in the next read of 0x11. A clear that is too wide or too narrow is exposed by the read that follows the clearing read. A broken link-edge detector shows as bit 2 either missing after a drop or appearing after a rise. Each of these faults is visible within two or three cycles of the stimulus. The sweep crosses every event with every enable pattern, so an interrupt-gating mistake on any single bit pair produces a wrong `phy_irq` level.

// File: rtl/phy_mgmt_pkg.sv
// Shared constants for the PHY management register block.
// Assumes a 5-bit register address space and 16-bit registers.
package phy_mgmt_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int NUM_EV = 8;
    localparam int AMP_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_IRQ  = 5'h11;
    localparam logic [ADDR_W-1:0] ADDR_DIAG = 5'h12;
    localparam logic [ADDR_W-1:0] ADDR_XCVR = 5'h13;

    // Status bit positions within the interrupt word
    localparam int EV_ANEG_DONE = 0;
    localparam int EV_RFAULT    = 1;
    localparam int EV_LINK_DOWN = 2;
    localparam int EV_LP_ACK    = 3;
    localparam int EV_PD_FAULT  = 4;
    localparam int EV_PAGE_RX   = 5;
    localparam int EV_RX_ERR    = 6;
    localparam int EV_JABBER    = 7;
endpackage

// File: rtl/link_fall_det.sv
// Detects a high-to-low transition of the link status level.
// Assumes link_ok is synchronous to clk. Reset value "down" means
// a link that is down from reset produces no event.
module link_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    output logic link_fall
);
    logic link_q;

    // Hold the previous link level
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= 1'b0;
        else        link_q <= link_ok;
    end

    // Fall = was OK, now not OK
    always_comb link_fall = link_q & ~link_ok;
endmodule

// File: rtl/irq_status_reg.sv
// Sticky event status with paired enables and combined interrupt.
// Assumes ev_set are one-cycle pulses; rd_hit clears only bits that
// were set at read time, and a same-cycle event wins over the clear.
module irq_status_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_set,
    input  logic         rd_hit,
    input  logic         wr_hit,
    input  logic [N-1:0] wr_en,
    output logic [N-1:0] stat_q,
    output logic [N-1:0] en_q,
    output logic         irq
);
    logic [N-1:0] clr_mask;

    // Bits to clear are those being returned by this read
    always_comb clr_mask = rd_hit ? stat_q : '0;

    // Status: keep, clear what was read, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | ev_set;
    end

    // Enables: plain write-only-on-hit storage
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_hit) en_q <= wr_en;
    end

    // Interrupt: any enabled pending event
    always_comb irq = |(stat_q & en_q);
endmodule

// File: rtl/diag_reg.sv
// Auto-negotiation diagnostic word: sticky failure flag plus live levels.
// Assumes fail_pulse is a one-cycle pulse; a pulse during the clearing
// read keeps the flag set.
module diag_reg #(
    parameter int DW = 16,
    parameter int FAIL_BIT = 12,
    parameter int LIVE_LSB = 8,
    parameter int LIVE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_pulse,
    input  logic              rd_hit,
    input  logic [LIVE_W-1:0] live,
    output logic [DW-1:0]     word
);
    logic fail_q;

    // Failure flag: set on pulse, cleared by read
    always_ff @(posedge clk) begin
        if (!rst_n) fail_q <= 1'b0;
        else        fail_q <= (fail_q & ~rd_hit) | fail_pulse;
    end

    // Assemble the word; unused positions are zero
    always_comb begin
        word = '0;
        word[FAIL_BIT] = fail_q;
        word[LIVE_LSB +: LIVE_W] = live;
    end
endmodule

// File: rtl/xcvr_ctrl_reg.sv
// Transmit amplitude code register, placed in the top bits of the word.
// Assumes writes are full-word; only the amplitude field is kept.
module xcvr_ctrl_reg #(
    parameter int DW = 16,
    parameter int AMP_W = 2,
    parameter logic [AMP_W-1:0] AMP_RST = 2'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] word
);
    localparam int AMP_LSB = DW - AMP_W;
    logic [AMP_W-1:0] amp_q;

    // Amplitude code storage
    always_ff @(posedge clk) begin
        if (!rst_n)      amp_q <= AMP_RST;
        else if (wr_hit) amp_q <= wdata[AMP_LSB +: AMP_W];
    end

    // Remaining bits read as zero
    always_comb word = {amp_q, {AMP_LSB{1'b0}}};
endmodule

// File: rtl/phy_mgmt_regs.sv
// PHY management registers: interrupt control/status, diagnostic and
// transceiver control, behind a single-cycle read/write port.
// Assumes all inputs are synchronous to clk; read data is combinational
// and clear-on-read takes effect at the edge ending the read cycle.
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic              mgmt_rd,
    input  logic              mgmt_wr,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output logic [DATA_W-1:0] mgmt_rdata,
    input  logic              ev_jabber,
    input  logic              ev_rx_err,
    input  logic              ev_page_rx,
    input  logic              ev_pd_fault,
    input  logic              ev_lp_ack,
    input  logic              ev_rfault,
    input  logic              ev_aneg_done,
    input  logic              link_ok,
    input  logic              aneg_fail,
    input  logic              st_full_duplex,
    input  logic              st_rate_100,
    input  logic              st_rx_signal,
    input  logic              st_rx_lock,
    output logic              phy_irq
);
    logic              sel_irq, sel_diag, sel_xcvr;
    logic              link_fall;
    logic [NUM_EV-1:0] ev_vec;
    logic [NUM_EV-1:0] irq_stat, irq_en;
    logic [DATA_W-1:0] diag_word, xcvr_word;

    // Address decode
    always_comb begin
        sel_irq  = (mgmt_addr == ADDR_IRQ);
        sel_diag = (mgmt_addr == ADDR_DIAG);
        sel_xcvr = (mgmt_addr == ADDR_XCVR);
    end

    link_fall_det u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_ok   (link_ok),
        .link_fall (link_fall)
    );

    // Gather event sources in status-bit order
    always_comb begin
        ev_vec = '0;
        ev_vec[EV_ANEG_DONE] = ev_aneg_done;
        ev_vec[EV_RFAULT]    = ev_rfault;
        ev_vec[EV_LINK_DOWN] = link_fall;
        ev_vec[EV_LP_ACK]    = ev_lp_ack;
        ev_vec[EV_PD_FAULT]  = ev_pd_fault;
        ev_vec[EV_PAGE_RX]   = ev_page_rx;
        ev_vec[EV_RX_ERR]    = ev_rx_err;
        ev_vec[EV_JABBER]    = ev_jabber;
    end

    irq_status_reg #(.N(NUM_EV)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_set (ev_vec),
        .rd_hit (mgmt_rd & sel_irq),
        .wr_hit (mgmt_wr & sel_irq),
        .wr_en  (mgmt_wdata[DATA_W-1 -: NUM_EV]),
        .stat_q (irq_stat),
        .en_q   (irq_en),
        .irq    (phy_irq)
    );

    diag_reg #(.DW(DATA_W), .FAIL_BIT(12), .LIVE_LSB(8), .LIVE_W(4)) u_diag (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_pulse (aneg_fail),
        .rd_hit     (mgmt_rd & sel_diag),
        .live       ({st_full_duplex, st_rate_100, st_rx_signal, st_rx_lock}),
        .word       (diag_word)
    );

    xcvr_ctrl_reg #(.DW(DATA_W), .AMP_W(AMP_W), .AMP_RST(2'd1)) u_xcvr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (mgmt_wr & sel_xcvr),
        .wdata  (mgmt_wdata),
        .word   (xcvr_word)
    );

    // Read mux; unmapped addresses return zero
    always_comb begin
        mgmt_rdata = '0;
        if (sel_irq)  mgmt_rdata = {irq_en, irq_stat};
        if (sel_diag) mgmt_rdata = diag_word;
        if (sel_xcvr) mgmt_rdata = xcvr_word;
    end
endmodule

// File: rtl/phy_mgmt_chk.sv
// Checker for phy_mgmt_regs, attached by bind below.
module phy_mgmt_chk
    import phy_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mgmt_addr,
    input logic              mgmt_rd,
    input logic [DATA_W-1:0] mgmt_rdata,
    input logic              link_ok,
    input logic              phy_irq,
    input logic [NUM_EV-1:0] ev_vec,
    input logic [NUM_EV-1:0] irq_stat,
    input logic [NUM_EV-1:0] irq_en
);
    logic rd_irq;
    logic mapped;
    always_comb rd_irq = mgmt_rd && (mgmt_addr == ADDR_IRQ);
    always_comb mapped = (mgmt_addr == ADDR_IRQ) || (mgmt_addr == ADDR_DIAG)
                      || (mgmt_addr == ADDR_XCVR);

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_irq |=> ((irq_stat & $past(irq_stat)) == $past(irq_stat)));

    assert_read_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_irq |=> (irq_stat == $past(ev_vec)));

    assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phy_irq |-> (irq_en != '0 && irq_stat != '0));

    assert_no_rise_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok |-> !ev_vec[EV_LINK_DOWN]);

    assert_diag_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_addr == ADDR_DIAG) |-> (mgmt_rdata[15:13] == 3'd0 && mgmt_rdata[7:0] == 8'd0));

    assert_xcvr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_addr == ADDR_XCVR) |-> (mgmt_rdata[13:0] == 14'd0));

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (mgmt_rdata == '0));
endmodule

bind phy_mgmt_regs phy_mgmt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mgmt_addr  (mgmt_addr),
    .mgmt_rd    (mgmt_rd),
    .mgmt_rdata (mgmt_rdata),
    .link_ok    (link_ok),
    .phy_irq    (phy_irq),
    .ev_vec     (ev_vec),
    .irq_stat   (irq_stat),
    .irq_en     (irq_en)
);

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  ev = '0;   // bench view: index = status bit, bit 2 unused
    logic        link = 1'b0, afail = 1'b0;
    logic [3:0]  live = '0; // {duplex, rate, signal, lock}
    logic        irq;
    int          n_run = 0, n_fail = 0;
    logic [15:0] d;

    always #4 clk = ~clk;

    phy_mgmt_regs u_dut (
        .clk(clk), .rst_n(rst_n), .mgmt_addr(addr), .mgmt_rd(rd), .mgmt_wr(wr),
        .mgmt_wdata(wdata), .mgmt_rdata(rdata),
        .ev_jabber(ev[7]), .ev_rx_err(ev[6]), .ev_page_rx(ev[5]), .ev_pd_fault(ev[4]),
        .ev_lp_ack(ev[3]), .ev_rfault(ev[1]), .ev_aneg_done(ev[0]),
        .link_ok(link), .aneg_fail(afail),
        .st_full_duplex(live[3]), .st_rate_100(live[2]), .st_rx_signal(live[1]),
        .st_rx_lock(live[0]), .phy_irq(irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_rd(input logic [4:0] a, output logic [15:0] q);
        @(negedge clk); addr = a; rd = 1'b1; #1 q = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk); addr = a; wdata = v; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic fire(input int i);
        if (i == 2) begin
            @(negedge clk); link = 1'b1;
            @(negedge clk); link = 1'b0;
            @(negedge clk);
        end else begin
            @(negedge clk); ev[i] = 1'b1;
            @(negedge clk); ev = '0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 chk({15'd0, irq}, 16'd0, "R1 irq");
        do_rd(5'h11, d); chk(d, 16'h0000, "R1 irq word");
        do_rd(5'h12, d); chk(d, 16'h0000, "R1 diag word");
        do_rd(5'h13, d); chk(d, 16'h4000, "R1 xcvr word");

        // R7 write touches enables only
        do_wr(5'h11, 16'hFFFF);
        do_rd(5'h11, d); chk(d, 16'hFF00, "R7 enable-only write");

        // R2/R3/R5 sweep: every event against every enable pattern
        for (int i = 0; i < 8; i++) begin
            for (int e = 0; e < 256; e++) begin
                do_wr(5'h11, {e[7:0], 8'hFF});
                fire(i);
                #1 chk({15'd0, irq}, {15'd0, e[i]}, "R5 irq level");
                do_rd(5'h11, d); chk(d, {e[7:0], 8'(1 << i)}, "R2 status set");
                do_rd(5'h11, d); chk(d, {e[7:0], 8'h00}, "R3 cleared after read");
            end
        end

        // R3: multiple bits set, one read clears all returned
        do_wr(5'h11, 16'h0000);
        fire(6); fire(3); fire(1);
        do_rd(5'h11, d); chk(d, 16'h004A, "R3 multi read");
        do_rd(5'h11, d); chk(d, 16'h0000, "R3 multi cleared");

        // R4 event in the same cycle as the clearing read
        fire(0); fire(7);
        @(negedge clk); addr = 5'h11; rd = 1'b1; ev[0] = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0; ev = '0;
        chk(d, 16'h0081, "R4 read data");
        do_rd(5'h11, d); chk(d, 16'h0001, "R4 bit survived");

        // R6 link rise only: no event
        @(negedge clk); link = 1'b0;
        @(negedge clk); link = 1'b1;
        repeat (2) @(negedge clk);
        do_rd(5'h11, d); chk(d, 16'h0000, "R6 rise ignored");
        @(negedge clk); link = 1'b0;
        repeat (2) @(negedge clk);
        do_rd(5'h11, d); chk(d, 16'h0004, "R6 fall sets bit2");

        // R8 live levels, all 16 combinations, and write ignored
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); live = v[3:0];
            do_rd(5'h12, d); chk(d, {4'd0, v[3:0], 8'd0}, "R8 live bits");
        end
        live = 4'd0;
        do_wr(5'h12, 16'hFFFF);
        do_rd(5'h12, d); chk(d, 16'h0000, "R8 write ignored");

        // R9 failure flag sticky, clear on read, survives coincident pulse
        @(negedge clk); afail = 1'b1; @(negedge clk); afail = 1'b0;
        repeat (3) @(negedge clk);
        do_rd(5'h12, d); chk(d, 16'h1000, "R9 flag set");
        do_rd(5'h12, d); chk(d, 16'h0000, "R9 flag cleared");
        @(negedge clk); afail = 1'b1; @(negedge clk); afail = 1'b0;
        @(negedge clk); addr = 5'h12; rd = 1'b1; afail = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0; afail = 1'b0;
        chk(d, 16'h1000, "R9 read with pulse");
        do_rd(5'h12, d); chk(d, 16'h1000, "R9 flag survived");
        do_rd(5'h12, d); chk(d, 16'h0000, "R9 flag cleared again");

        // R10 amplitude codes
        for (int c = 0; c < 4; c++) begin
            do_wr(5'h13, {c[1:0], 14'h3FFF});
            do_rd(5'h13, d); chk(d, {c[1:0], 14'd0}, "R10 amplitude code");
        end

        // R11 unmapped addresses
        do_wr(5'h11, 16'hA500);
        do_wr(5'h13, 16'h8000);
        for (int a = 0; a < 32; a++) begin
            if (a < 5'h11 || a > 5'h13) begin
                do_wr(a[4:0], 16'hFFFF);
                do_rd(a[4:0], d); chk(d, 16'h0000, "R11 unmapped read");
            end
        end
        do_rd(5'h11, d); chk(d, 16'hA500, "R11 irq word untouched");
        do_rd(5'h12, d); chk(d, 16'h0000, "R11 diag word untouched");
        do_rd(5'h13, d); chk(d, 16'h8000, "R11 xcvr word untouched");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule